// File: doc/BRIEF.md
# Link-Side Receive Decoder for a PHY Parallel Interface

This block sits on the link side of a parallel PHY-to-link interface and turns the PHY's receive traffic into a packet byte stream. On every system clock it samples a 2-bit control bus and an 8-bit data bus. A receive begins when the control bus shows the receive code, and the PHY may enter it straight from a status transfer.

Once a receive has begun, the block skips any leading data-on bytes and decodes the first other byte as the speed code. It then forwards each following byte on a valid/data/start/end stream that carries the decoded speed. A packet whose speed is malformed or above the configured link capability is dropped silently, with only a single reject pulse to show for it. A receive made only of data-on bytes is reported as a null packet. A receive that ends straight after its speed code is reported as an empty packet.

The stream holds each byte back by one cycle, so that the end mark can sit on the last byte. It is meant to feed a packet buffer or a CRC checker directly.

Top module: `phyrx_receiver`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, every output (rx_valid, rx_sop, rx_eop, rx_reject, rx_null, rx_empty) is low.
- R2: A receive starts when phy_ctl reads 2'b10, whether the previous cycle was idle (2'b00) or status (2'b01). Samples taken with phy_ctl at 2'b00, 2'b01 or 2'b11 outside a receive produce no stream bytes and no pulses.
- R3: During a receive and before the speed code, every byte whose bits [7:6] are 2'b11 is a data-on byte. It is skipped whatever its low six bits hold.
- R4: The speed byte decodes as follows. Bits [7:6]=00 gives rx_speed 0 (S100). Bits [7:4]=0100 gives 1 (S200). Exactly 8'h50 gives 2 (S400). Don't-care bits are ignored. rx_speed holds the decoded value for the whole packet.
- R5: A speed byte that fits none of the R4 patterns, or that decodes above link_cap, causes exactly one rx_reject pulse and no stream bytes for the rest of that receive. link_cap uses the R4 encoding, and the value 3 is treated as 2.
- R6: After an accepted speed code, each cycle with phy_ctl at 2'b10 delivers one byte, forwarded in order even when its top bits are 11.
- R7: rx_sop marks the first byte and rx_eop the last byte before the receive ends. A byte sampled at edge k appears on the stream after edge k+1.
- R8: A receive that ends after data-on bytes only gives one rx_null pulse, no reject and no stream bytes.
- R9: A receive that ends right after an accepted speed code gives one rx_empty pulse and no stream bytes.
- R10: rx_reject, rx_null and rx_empty are single-cycle pulses, and no two of them are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared with the PHY |
| rst_n | input | 1 | Active-low synchronous reset |
| link_cap | input | 2 | Highest accepted speed (0 S100, 1 S200, 2 or 3 S400) |
| phy_ctl | input | 2 | Control bus from the PHY |
| phy_d | input | 8 | Data bus from the PHY |
| rx_valid | output | 1 | Stream byte valid |
| rx_data | output | 8 | Stream byte |
| rx_sop | output | 1 | First byte of a packet |
| rx_eop | output | 1 | Last byte of a packet |
| rx_speed | output | 2 | Decoded speed of the current packet |
| rx_reject | output | 1 | Pulse: packet dropped for its speed |
| rx_null | output | 1 | Pulse: null packet seen |
| rx_empty | output | 1 | Pulse: packet ended with no data |

## Verification
If the sequencer were stuck in its skip state, data-on filtering would leak. A speed byte would then be missing from the stream, or it would appear as data, and this shows in the first stream byte one cycle after that byte's edge. A wrong drop or accept decision shows within one cycle as a reject pulse together with stream bytes, or as neither. A hold register that is lost or doubled shows by the end of the packet as a wrong byte count or a misplaced start or end mark.

// File: rtl/phyrx_pkg.sv
package phyrx_pkg;
  localparam int DW = 8;
  localparam int CW = 2;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'b00,
    CTL_STAT = 2'b01,
    CTL_RECV = 2'b10,
    CTL_XMIT = 2'b11
  } ctl_e;

  typedef enum logic [1:0] {
    SPD_100 = 2'd0,
    SPD_200 = 2'd1,
    SPD_400 = 2'd2,
    SPD_BAD = 2'd3
  } spd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SKIP,
    ST_PASS,
    ST_DROP
  } seq_e;

  function automatic logic is_dataon(input logic [DW-1:0] b);
    return b[DW-1 -: 2] == 2'b11;
  endfunction

  function automatic spd_e decode_speed(input logic [DW-1:0] b);
    if (b[DW-1 -: 2] == 2'b00)      return SPD_100;
    else if (b[DW-1 -: 4] == 4'b0100) return SPD_200;
    else if (b == 8'h50)            return SPD_400;
    else                            return SPD_BAD;
  endfunction

  function automatic logic speed_allowed(input spd_e s, input logic [1:0] cap);
    logic [1:0] lim;
    lim = (cap == 2'd3) ? 2'd2 : cap;
    return (s != SPD_BAD) && (s <= lim);
  endfunction
endpackage

// File: rtl/phyrx_classify.sv
module phyrx_classify
  import phyrx_pkg::*;
(
  input  logic [CW-1:0] ctl,
  input  logic [DW-1:0] dbus,
  input  logic [1:0]    cap,
  output logic          recv,
  output logic          dataon,
  output logic          spd_ok,
  output spd_e          spd
);
  always_comb begin
    recv   = (ctl == CTL_RECV);
    dataon = is_dataon(dbus);
    spd    = decode_speed(dbus);
    spd_ok = speed_allowed(spd, cap);
  end
endmodule

// File: rtl/phyrx_seq.sv
module phyrx_seq
  import phyrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic recv,
  input  logic dataon,
  input  logic spd_ok,
  output logic ev_accept,
  output logic ev_capture,
  output logic ev_close,
  output logic rej_pulse,
  output logic null_pulse,
  output seq_e st
);
  seq_e nxt;
  logic ev_reject, ev_null;

  always_comb begin
    nxt        = st;
    ev_accept  = 1'b0;
    ev_reject  = 1'b0;
    ev_capture = 1'b0;
    ev_close   = 1'b0;
    ev_null    = 1'b0;
    case (st)
      ST_IDLE, ST_SKIP: begin
        if (recv) begin
          if (dataon)      nxt = ST_SKIP;
          else if (spd_ok) begin ev_accept = 1'b1; nxt = ST_PASS; end
          else             begin ev_reject = 1'b1; nxt = ST_DROP; end
        end else begin
          ev_null = (st == ST_SKIP);
          nxt     = ST_IDLE;
        end
      end
      ST_PASS: begin
        if (recv) ev_capture = 1'b1;
        else begin ev_close = 1'b1; nxt = ST_IDLE; end
      end
      default: if (!recv) nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      rej_pulse  <= 1'b0;
      null_pulse <= 1'b0;
    end else begin
      st         <= nxt;
      rej_pulse  <= ev_reject;
      null_pulse <= ev_null;
    end
  end

  assert_rej_leads_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |-> st == ST_DROP);
  assert_null_from_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    null_pulse |-> ($past(st) == ST_SKIP && st == ST_IDLE));
endmodule

// File: rtl/phyrx_stream.sv
module phyrx_stream
  import phyrx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_accept,
  input  logic          ev_capture,
  input  logic          ev_close,
  input  logic [DW-1:0] din,
  input  spd_e          spd_in,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop,
  output spd_e          out_speed,
  output logic          empty_pulse
);
  logic [DW-1:0] hold_q;
  logic          hold_vld, first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_vld    <= 1'b0;
      first_q     <= 1'b0;
      out_speed   <= SPD_100;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_sop     <= 1'b0;
      out_eop     <= 1'b0;
      empty_pulse <= 1'b0;
    end else begin
      out_valid   <= 1'b0;
      out_sop     <= 1'b0;
      out_eop     <= 1'b0;
      empty_pulse <= 1'b0;
      if (ev_accept) begin
        out_speed <= spd_in;
        first_q   <= 1'b1;
        hold_vld  <= 1'b0;
      end
      if (ev_capture) begin
        if (hold_vld) begin
          out_valid <= 1'b1;
          out_data  <= hold_q;
          out_sop   <= first_q;
          first_q   <= 1'b0;
        end
        hold_q   <= din;
        hold_vld <= 1'b1;
      end
      if (ev_close) begin
        if (hold_vld) begin
          out_valid <= 1'b1;
          out_data  <= hold_q;
          out_sop   <= first_q;
          out_eop   <= 1'b1;
        end else begin
          empty_pulse <= 1'b1;
        end
        hold_vld <= 1'b0;
        first_q  <= 1'b0;
      end
    end
  end

  assert_marks_need_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop || out_eop) |-> out_valid);
  assert_speed_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> $stable(out_speed));
endmodule

// File: rtl/phyrx_receiver.sv
module phyrx_receiver
  import phyrx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    link_cap,
  input  logic [CW-1:0] phy_ctl,
  input  logic [DW-1:0] phy_d,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rx_sop,
  output logic          rx_eop,
  output logic [1:0]    rx_speed,
  output logic          rx_reject,
  output logic          rx_null,
  output logic          rx_empty
);
  logic recv, dataon, spd_ok;
  spd_e spd, spd_out;
  logic ev_accept, ev_capture, ev_close;
  seq_e seq_state;

  phyrx_classify u_cls (
    .ctl(phy_ctl), .dbus(phy_d), .cap(link_cap),
    .recv(recv), .dataon(dataon), .spd_ok(spd_ok), .spd(spd)
  );

  phyrx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .recv(recv), .dataon(dataon), .spd_ok(spd_ok),
    .ev_accept(ev_accept), .ev_capture(ev_capture), .ev_close(ev_close),
    .rej_pulse(rx_reject), .null_pulse(rx_null), .st(seq_state)
  );

  phyrx_stream u_str (
    .clk(clk), .rst_n(rst_n), .ev_accept(ev_accept), .ev_capture(ev_capture),
    .ev_close(ev_close), .din(phy_d), .spd_in(spd),
    .out_valid(rx_valid), .out_data(rx_data), .out_sop(rx_sop), .out_eop(rx_eop),
    .out_speed(spd_out), .empty_pulse(rx_empty)
  );

  assign rx_speed = spd_out;

  assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_reject, rx_null, rx_empty}));
  assert_no_stream_in_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state == ST_DROP |-> !rx_valid);
  assert_eop_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eop |-> seq_state == ST_IDLE);
endmodule

// File: tb/tb_phyrx_receiver.sv
`timescale 1ns/1ps
module tb_phyrx_receiver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] link_cap = 2'd2;
  logic [1:0] phy_ctl = 2'b00;
  logic [7:0] phy_d = 8'h00;
  logic       rx_valid, rx_sop, rx_eop, rx_reject, rx_null, rx_empty;
  logic [7:0] rx_data;
  logic [1:0] rx_speed;

  phyrx_receiver dut (
    .clk(clk), .rst_n(rst_n), .link_cap(link_cap), .phy_ctl(phy_ctl), .phy_d(phy_d),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .rx_speed(rx_speed), .rx_reject(rx_reject), .rx_null(rx_null), .rx_empty(rx_empty)
  );

  always #2 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  logic [7:0] got[$];
  int sop_cnt, eop_cnt, sop_idx, eop_idx, sop_cyc, rej_cnt, null_cnt, empty_cnt;
  logic [1:0] spd_seen;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    got.delete();
    sop_cnt = 0; eop_cnt = 0; sop_idx = -1; eop_idx = -1; sop_cyc = -1;
    rej_cnt = 0; null_cnt = 0; empty_cnt = 0; spd_seen = 2'd3;
  endtask

  task automatic drive(input logic [1:0] c, input logic [7:0] d);
    @(negedge clk);
    phy_ctl = c; phy_d = d;
    @(posedge clk);
    #1;
    cyc++;
    if (rx_valid) begin
      got.push_back(rx_data);
      if (rx_sop) begin sop_cnt++; sop_idx = got.size() - 1; sop_cyc = cyc; spd_seen = rx_speed; end
      if (rx_eop) begin eop_cnt++; eop_idx = got.size() - 1; end
    end
    if (rx_reject) rej_cnt++;
    if (rx_null)   null_cnt++;
    if (rx_empty)  empty_cnt++;
  endtask

  // returns the cycle index at which the first data byte was sampled
  task automatic send_pkt(input int n_on, input logic [7:0] spd, input int len,
                          input logic [7:0] base, output int first_cyc);
    for (int i = 0; i < n_on; i++) drive(2'b10, 8'hC0 | 8'(i * 5));
    drive(2'b10, spd);
    first_cyc = cyc + 1;
    for (int i = 0; i < len; i++) drive(2'b10, base + 8'(i));
    drive(2'b00, 8'h00);
    drive(2'b00, 8'h00);
  endtask

  task automatic t_reset();
    check(!rx_valid && !rx_sop && !rx_eop && !rx_reject && !rx_null && !rx_empty,
          "R1 outputs idle after reset", {rx_valid, rx_sop, rx_eop, rx_reject, rx_null, rx_empty}, 0);
  endtask

  task automatic t_basic();
    int fc;
    link_cap = 2'd2; clear_log();
    send_pkt(2, 8'h00, 5, 8'h10, fc);
    check(got.size() == 5, "R6 byte count", got.size(), 5);
    for (int i = 0; i < got.size(); i++)
      check(got[i] == 8'h10 + 8'(i), "R6 byte order", got[i], 8'h10 + i);
    check(sop_cnt == 1 && sop_idx == 0, "R7 sop on first byte", sop_idx, 0);
    check(eop_cnt == 1 && eop_idx == 4, "R7 eop on last byte", eop_idx, 4);
    check(sop_cyc == fc + 1, "R7 one-cycle latency", sop_cyc, fc + 1);
    check(spd_seen == 2'd0, "R4 S100 decode", spd_seen, 0);
    check(rej_cnt == 0 && null_cnt == 0 && empty_cnt == 0, "R10 no stray pulse", rej_cnt + null_cnt + empty_cnt, 0);
  endtask

  task automatic t_single_s200();
    int fc;
    link_cap = 2'd1; clear_log();
    send_pkt(0, 8'h4A, 1, 8'hFE, fc);
    check(got.size() == 1 && got[0] == 8'hFE, "R6 data-on-like byte forwarded", got.size(), 1);
    check(sop_idx == 0 && eop_idx == 0, "R7 sop and eop on one byte", eop_idx, 0);
    check(spd_seen == 2'd1, "R4 S200 decode with don't-care bits", spd_seen, 1);
  endtask

  task automatic t_s400_cap();
    int fc;
    link_cap = 2'd2; clear_log();
    send_pkt(1, 8'h50, 3, 8'h80, fc);
    check(got.size() == 3 && spd_seen == 2'd2, "R4 S400 decode", spd_seen, 2);
    link_cap = 2'd1; clear_log();
    send_pkt(1, 8'h50, 3, 8'h80, fc);
    check(got.size() == 0, "R5 over-capability dropped", got.size(), 0);
    check(rej_cnt == 1, "R5 one reject pulse", rej_cnt, 1);
    link_cap = 2'd3; clear_log();
    send_pkt(0, 8'h50, 2, 8'h20, fc);
    check(got.size() == 2 && rej_cnt == 0, "R5 cap 3 acts as S400", got.size(), 2);
    link_cap = 2'd0; clear_log();
    send_pkt(0, 8'h40, 2, 8'h20, fc);
    check(got.size() == 0 && rej_cnt == 1, "R5 S200 above S100 cap", rej_cnt, 1);
  endtask

  task automatic t_invalid();
    int fc;
    link_cap = 2'd2; clear_log();
    send_pkt(1, 8'h51, 4, 8'h30, fc);
    check(got.size() == 0 && rej_cnt == 1, "R5 malformed speed 0x51", got.size(), 0);
    clear_log();
    send_pkt(0, 8'h60, 4, 8'h30, fc);
    check(got.size() == 0 && rej_cnt == 1, "R5 malformed speed 0x60", rej_cnt, 1);
    check(null_cnt == 0 && empty_cnt == 0, "R10 reject alone", null_cnt + empty_cnt, 0);
  endtask

  task automatic t_null();
    link_cap = 2'd2; clear_log();
    drive(2'b10, 8'hFF); drive(2'b10, 8'hFF); drive(2'b10, 8'hC3);
    drive(2'b00, 8'h00); drive(2'b00, 8'h00);
    check(null_cnt == 1, "R8 null pulse", null_cnt, 1);
    check(got.size() == 0 && rej_cnt == 0 && empty_cnt == 0, "R8 null has no bytes", got.size(), 0);
  endtask

  task automatic t_empty();
    link_cap = 2'd2; clear_log();
    drive(2'b10, 8'hFF); drive(2'b10, 8'h00);
    drive(2'b00, 8'h00); drive(2'b00, 8'h00);
    check(empty_cnt == 1, "R9 empty pulse", empty_cnt, 1);
    check(got.size() == 0 && null_cnt == 0, "R9 empty has no bytes", got.size(), 0);
  endtask

  task automatic t_status_and_xmit();
    link_cap = 2'd2; clear_log();
    drive(2'b01, 8'h12); drive(2'b11, 8'h00); drive(2'b11, 8'h50);
    drive(2'b01, 8'h40); drive(2'b00, 8'h00);
    check(got.size() == 0 && rej_cnt + null_cnt + empty_cnt == 0,
          "R2 status/transmit ignored", got.size(), 0);
    clear_log();
    drive(2'b01, 8'h05); drive(2'b01, 8'h07);
    drive(2'b10, 8'hD7); drive(2'b10, 8'h3F);
    drive(2'b10, 8'hA1); drive(2'b10, 8'hA2);
    drive(2'b00, 8'h00); drive(2'b00, 8'h00);
    check(got.size() == 2, "R2 receive straight from status", got.size(), 2);
    check(got.size() > 0 && got[0] == 8'hA1, "R3 data-on 0xD7 skipped", got.size() > 0 ? got[0] : -1, 8'hA1);
    check(spd_seen == 2'd0, "R4 0x3F decodes as S100", spd_seen, 0);
  endtask

  initial begin
    clear_log();
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_single_s200();
    t_s400_cap();
    t_invalid();
    t_null();
    t_empty();
    t_status_and_xmit();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule